// File: doc/BRIEF.md
# Serial Character Transmitter with Line Control

This block turns bytes written by a processor into asynchronous serial characters. Bytes enter a small first-in first-out buffer through a single-cycle push port. A sequencer takes them one at a time and sends each as a framed character: a start bit at 0, then the data bits least significant first, an optional parity bit, and a stop period at 1. Every bit lasts a fixed number of ticks of a 16x baud enable that arrives from outside the block.

The character format comes from a set of line-control inputs: data length, parity on or off, the parity sense, a forced-parity option and a longer stop period. A break input holds the pin low without changing the frame sequence underneath. A loopback input keeps the pin at the idle level and shows the internal serial stream on a separate port, for a neighbouring receiver. Two flags report progress. One says the buffer holds no bytes. The other says the buffer is empty and no character is being sent either. A flush input empties the buffer but lets the character already in flight finish.

Top module: `uart_tx_line`

## Requirements
- R1: After reset, `ser_out` and `loop_out` are 1, and `hold_empty` and `xmit_empty` are both 1.
- R2: Each character starts with a 0 start bit. The data bits follow, least significant first, and their count is 5, 6, 7 or 8 for `lc_len` = 0, 1, 2, 3. Every start, data and parity bit lasts exactly 16 baud ticks, and the line changes only on a cycle where `baud_tick` is high.
- R3: When `lc_par_en` = 1 and `lc_stick` = 0, a parity bit is sent after the last data bit. With `lc_even` = 1, the data bits and the parity bit together hold an even number of ones. With `lc_even` = 0, they hold an odd number.
- R4: When `lc_par_en` = 1 and `lc_stick` = 1, the parity bit is 0 if `lc_even` = 1 and 1 if `lc_even` = 0.
- R5: With `lc_stop2` = 0, the stop period is 16 ticks at 1. With `lc_stop2` = 1, it is 24 ticks for 5-bit characters and 32 ticks for 6-, 7- and 8-bit characters.
- R6: While `lc_break` = 1 and `loop_en` = 0, `ser_out` is 0. The character sequence seen on `loop_out` is unchanged.
- R7: `hold_empty` is 1 exactly when the buffer holds no bytes. It goes to 0 in the cycle after an accepted push.
- R8: `xmit_empty` is 1 only when the buffer is empty and no character is in progress. While the last character is still being sent, `hold_empty` = 1 and `xmit_empty` = 0.
- R9: While `loop_en` = 1, `ser_out` stays at 1 and `loop_out` carries the character stream.
- R10: A `flush` pulse empties the buffer, so `hold_empty` = 1 in the next cycle. The character already in flight is still sent in full, and no later byte is sent.
- R11: The buffer holds 16 bytes. A push while it is full is ignored, so only the first 16 of 17 pushed bytes are sent.
- R12: When the buffer is not empty at the tick that ends a stop period, the next start bit begins on that same tick, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | 16x baud enable, one cycle wide |
| push_valid | input | 1 | Write `push_data` into the buffer |
| push_data | input | 8 | Byte to send |
| flush | input | 1 | Empty the buffer |
| lc_len | input | 2 | Data length: 0..3 selects 5..8 bits |
| lc_par_en | input | 1 | Send a parity bit |
| lc_even | input | 1 | Parity sense: 1 even, 0 odd |
| lc_stick | input | 1 | Force the parity bit to the inverse of `lc_even` |
| lc_stop2 | input | 1 | Longer stop period |
| lc_break | input | 1 | Hold `ser_out` low |
| loop_en | input | 1 | Loopback: pin held at 1 |
| ser_out | output | 1 | Serial line |
| loop_out | output | 1 | Internal serial stream |
| hold_empty | output | 1 | Buffer empty |
| xmit_empty | output | 1 | Buffer empty and sequencer idle |

## Verification
The assertions assume that `push_valid` and `flush` are ordinary one-cycle controls, and that `baud_tick` is the only event that may change the line. They also assume that the line-control inputs do not change while a character is being sent. The stimulus respects this: it changes the format, break and loopback inputs only after `xmit_empty` has returned to 1, and it drives every input half a cycle away from the active edge. Random formats and bytes from a seeded generator are mixed with directed runs for the longer stop periods, the fixed-parity values, a full buffer, a flush in mid-character, break and loopback.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    localparam int DATA_W        = 8;
    localparam int MIN_LEN       = 5;
    localparam int TICKS_PER_BIT = 16;
    localparam int CNT_W         = $clog2(2 * TICKS_PER_BIT);
    localparam int IDX_W         = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       even;
        logic       stick;
        logic       stop2;
    } line_cfg_t;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
    assign rdata = mem_q[q.rd];

    always_comb begin
        d       = q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wr = step(q.wr);
            if (do_pop)  d.rd = step(q.rd);
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q.wr] <= wdata;
    end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
    import uart_tx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  line_cfg_t         cfg,
    output logic              par_bit
);
    logic [DATA_W-1:0] masked;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = data[i] && (i < (MIN_LEN + int'(cfg.len)));
        end
        if (cfg.stick) par_bit = ~cfg.even;
        else if (cfg.even) par_bit = ^masked;
        else par_bit = ~^masked;
    end
endmodule

// File: rtl/uart_tx_frame_seq.sv
module uart_tx_frame_seq
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  line_cfg_t         cfg,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic              pop,
    output logic              line,
    output logic              busy
);
    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              par;
        logic              line;
    } seq_t;

    seq_t q, d;
    logic start_next;
    logic par_bit;
    logic [CNT_W-1:0] bit_last;
    logic [CNT_W-1:0] stop_last;
    logic [IDX_W-1:0] idx_last;

    uart_tx_parity par_i (
        .data    (fifo_rdata),
        .cfg     (cfg),
        .par_bit (par_bit)
    );

    assign bit_last  = CNT_W'(TICKS_PER_BIT - 1);
    assign stop_last = !cfg.stop2 ? CNT_W'(TICKS_PER_BIT - 1) :
                       (cfg.len == 2'd0) ? CNT_W'(3 * TICKS_PER_BIT / 2 - 1) :
                                           CNT_W'(2 * TICKS_PER_BIT - 1);
    assign idx_last  = IDX_W'(MIN_LEN - 1) + IDX_W'(cfg.len);

    always_comb begin
        d          = q;
        pop        = 1'b0;
        start_next = 1'b0;
        if (tick) begin
            case (q.st)
                ST_IDLE: start_next = !fifo_empty;
                ST_START: begin
                    if (q.cnt == bit_last) begin
                        d.st   = ST_DATA;
                        d.cnt  = '0;
                        d.idx  = '0;
                        d.line = q.shreg[0];
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (q.cnt == bit_last) begin
                        d.cnt = '0;
                        if (q.idx == idx_last) begin
                            d.st   = cfg.par_en ? ST_PAR : ST_STOP;
                            d.line = cfg.par_en ? q.par : 1'b1;
                        end else begin
                            d.idx   = q.idx + 1'b1;
                            d.shreg = q.shreg >> 1;
                            d.line  = q.shreg[1];
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (q.cnt == bit_last) begin
                        d.st   = ST_STOP;
                        d.cnt  = '0;
                        d.line = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (q.cnt == stop_last) begin
                        start_next = !fifo_empty;
                        d.st       = ST_IDLE;
                        d.cnt      = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d = q;
            endcase
            if (start_next) begin
                pop     = 1'b1;
                d.st    = ST_START;
                d.cnt   = '0;
                d.idx   = '0;
                d.shreg = fifo_rdata;
                d.par   = par_bit;
                d.line  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, idx: '0, shreg: '0, par: 1'b0, line: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign line = q.line;
    assign busy = (q.st != ST_IDLE);
endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              flush,
    input  logic [1:0]        lc_len,
    input  logic              lc_par_en,
    input  logic              lc_even,
    input  logic              lc_stick,
    input  logic              lc_stop2,
    input  logic              lc_break,
    input  logic              loop_en,
    output logic              ser_out,
    output logic              loop_out,
    output logic              hold_empty,
    output logic              xmit_empty
);
    line_cfg_t         cfg;
    logic              fifo_empty, fifo_full, fifo_pop;
    logic [DATA_W-1:0] fifo_rdata;
    logic              seq_line, seq_busy;

    assign cfg = '{len: lc_len, par_en: lc_par_en, even: lc_even,
                   stick: lc_stick, stop2: lc_stop2};

    uart_tx_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_valid),
        .wdata (push_data),
        .pop   (fifo_pop),
        .flush (flush),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    uart_tx_frame_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .cfg        (cfg),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .pop        (fifo_pop),
        .line       (seq_line),
        .busy       (seq_busy)
    );

    assign loop_out   = seq_line;
    assign ser_out    = loop_en ? 1'b1 : (lc_break ? 1'b0 : seq_line);
    assign hold_empty = fifo_empty;
    assign xmit_empty = fifo_empty && !seq_busy;
endmodule

// File: rtl/uart_tx_line_chk.sv
module uart_tx_line_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic push_valid,
    input logic flush,
    input logic lc_break,
    input logic loop_en,
    input logic ser_out,
    input logic loop_out,
    input logic hold_empty,
    input logic xmit_empty
);
    a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_empty |-> loop_out);

    a_r2_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(loop_out));

    a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_break && !loop_en) |-> !ser_out);

    a_r7_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !flush) |=> !hold_empty);

    a_r8_empty_order: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_empty |-> hold_empty);

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> hold_empty);
endmodule

bind uart_tx_line uart_tx_line_chk chk_i (.*);

// File: tb/uart_tx_line_tb_top.sv
module uart_tx_line_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       flush = 1'b0;
    logic [1:0] lc_len = 2'd3;
    logic       lc_par_en = 1'b0;
    logic       lc_even = 1'b0;
    logic       lc_stick = 1'b0;
    logic       lc_stop2 = 1'b0;
    logic       lc_break = 1'b0;
    logic       loop_en = 1'b0;
    logic       ser_out, loop_out, hold_empty, xmit_empty;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    bit  tick_on = 1'b0;
    bit  rec_on = 1'b0;
    int  div = 0;
    bit  trace_s[$];
    bit  trace_l[$];
    bit  exp_q[$];

    uart_tx_line dut_i (.*);

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            if (baud_tick && rec_on) begin
                trace_s.push_back(ser_out);
                trace_l.push_back(loop_out);
            end
            if (tick_on) begin
                div = (div + 1) % 3;
                baud_tick = (div == 0);
            end else begin
                baud_tick = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic void add_frame(input logic [7:0] b);
        int   nb = 5 + int'(lc_len);
        int   nstop;
        logic p;
        logic [7:0] m;
        m = b & 8'((1 << nb) - 1);
        repeat (16) exp_q.push_back(1'b0);
        for (int i = 0; i < nb; i++) repeat (16) exp_q.push_back(m[i]);
        if (lc_par_en) begin
            if (lc_stick) p = ~lc_even;
            else if (lc_even) p = ^m;
            else p = ~^m;
            repeat (16) exp_q.push_back(p);
        end
        nstop = !lc_stop2 ? 16 : (nb == 5 ? 24 : 32);
        repeat (nstop) exp_q.push_back(1'b1);
    endfunction

    task automatic push_byte(input logic [7:0] b);
        push_valid = 1'b1;
        push_data  = b;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic start_rec();
        trace_s.delete();
        trace_l.delete();
        exp_q.delete();
        rec_on = 1'b1;
    endtask

    task automatic finish_rec();
        while (!xmit_empty) @(negedge clk);
        repeat (120) @(negedge clk);
        rec_on = 1'b0;
    endtask

    task automatic compare_trace(input string req, input bit use_loop);
        bit tr[$];
        int start = -1;
        int bad = -1;
        if (use_loop) tr = trace_l;
        else tr = trace_s;
        for (int i = 0; i < tr.size(); i++) begin
            if (tr[i] == 1'b0) begin
                start = i;
                break;
            end
        end
        check(start >= 0, req, "start bit seen", start, 0);
        if (start < 0) return;
        for (int i = 0; i < exp_q.size(); i++) begin
            if (start + i >= tr.size() || tr[start + i] != exp_q[i]) begin
                bad = i;
                break;
            end
        end
        check(bad < 0, req, "tick stream first bad index", bad, -1);
        if (start + exp_q.size() < tr.size())
            check(tr[start + exp_q.size()] == 1'b1, req, "idle after frames",
                  int'(tr[start + exp_q.size()]), 1);
    endtask

    task automatic set_cfg(input logic [1:0] len, input logic pe, input logic ev,
                           input logic st, input logic s2);
        lc_len = len; lc_par_en = pe; lc_even = ev; lc_stick = st; lc_stop2 = s2;
    endtask

    task automatic burst(input string req, input logic [7:0] b0, input int n);
        start_rec();
        for (int i = 0; i < n; i++) begin
            add_frame(b0 + 8'(i * 37));
            push_byte(b0 + 8'(i * 37));
        end
        finish_rec();
        compare_trace(req, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ser_out == 1'b1, "R1", "ser_out after reset", int'(ser_out), 1);
        check(hold_empty == 1'b1, "R1", "hold_empty after reset", int'(hold_empty), 1);
        check(xmit_empty == 1'b1, "R1", "xmit_empty after reset", int'(xmit_empty), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(loop_out == 1'b1, "R1", "loop_out idle", int'(loop_out), 1);

        // R7 push clears hold_empty; R8 xmit_empty waits for the shifter
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        start_rec();
        add_frame(8'hA5);
        push_byte(8'hA5);
        check(hold_empty == 1'b0, "R7", "hold_empty after push", int'(hold_empty), 0);
        check(xmit_empty == 1'b0, "R8", "xmit_empty after push", int'(xmit_empty), 0);
        tick_on = 1'b1;
        while (ser_out) @(negedge clk);
        check(hold_empty == 1'b1, "R7", "hold_empty after pop", int'(hold_empty), 1);
        check(xmit_empty == 1'b0, "R8", "xmit_empty while sending", int'(xmit_empty), 0);
        finish_rec();
        check(xmit_empty == 1'b1, "R8", "xmit_empty when done", int'(xmit_empty), 1);
        compare_trace("R2", 1'b0);

        // R2 lengths, R12 back-to-back
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0); burst("R2", 8'h3B, 2);
        set_cfg(2'd1, 1'b0, 1'b0, 1'b0, 1'b0); burst("R2", 8'hC6, 2);
        set_cfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0); burst("R12", 8'h59, 3);
        // R3 parity sense
        set_cfg(2'd3, 1'b1, 1'b1, 1'b0, 1'b0); burst("R3", 8'h07, 2);
        set_cfg(2'd3, 1'b1, 1'b0, 1'b0, 1'b0); burst("R3", 8'h07, 2);
        // R4 stick parity
        set_cfg(2'd1, 1'b1, 1'b1, 1'b1, 1'b0); burst("R4", 8'hFF, 2);
        set_cfg(2'd1, 1'b1, 1'b0, 1'b1, 1'b0); burst("R4", 8'h00, 2);
        // R5 stop lengths
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b1); burst("R5", 8'h15, 2);
        set_cfg(2'd3, 1'b1, 1'b1, 1'b0, 1'b1); burst("R5", 8'h81, 2);

        // R6 break: pin low, internal stream intact
        set_cfg(2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        lc_break = 1'b1;
        start_rec();
        add_frame(8'h96); push_byte(8'h96);
        add_frame(8'h2D); push_byte(8'h2D);
        finish_rec();
        begin
            int ones = 0;
            foreach (trace_s[i]) if (trace_s[i]) ones++;
            check(ones == 0, "R6", "ser_out high samples under break", ones, 0);
        end
        compare_trace("R6", 1'b1);
        lc_break = 1'b0;

        // R9 loopback
        loop_en = 1'b1;
        start_rec();
        add_frame(8'h4E); push_byte(8'h4E);
        finish_rec();
        begin
            int zeros = 0;
            foreach (trace_s[i]) if (!trace_s[i]) zeros++;
            check(zeros == 0, "R9", "ser_out low samples in loopback", zeros, 0);
        end
        compare_trace("R9", 1'b1);
        loop_en = 1'b0;

        // R10 flush during a character
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        start_rec();
        add_frame(8'h11);
        push_byte(8'h11); push_byte(8'h22); push_byte(8'h33); push_byte(8'h44);
        while (ser_out) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check(hold_empty == 1'b1, "R10", "hold_empty after flush", int'(hold_empty), 1);
        check(xmit_empty == 1'b0, "R10", "shifter still busy", int'(xmit_empty), 0);
        finish_rec();
        compare_trace("R10", 1'b0);

        // R11 full buffer drops the 17th push
        tick_on = 1'b0;
        repeat (4) @(negedge clk);
        start_rec();
        for (int i = 0; i < 17; i++) begin
            if (i < 16) add_frame(8'(8'h40 + i));
            push_byte(8'(8'h40 + i));
        end
        check(hold_empty == 1'b0, "R11", "hold_empty with full buffer", int'(hold_empty), 0);
        tick_on = 1'b1;
        finish_rec();
        compare_trace("R11", 1'b0);

        // random formats: R2 R3 R4 R5 R12
        for (int r = 0; r < 20; r++) begin
            int n;
            set_cfg(2'($urandom_range(3)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                    1'($urandom_range(1)), 1'($urandom_range(1)));
            n = $urandom_range(1, 4);
            start_rec();
            for (int i = 0; i < n; i++) begin
                logic [7:0] b;
                b = 8'($urandom);
                add_frame(b);
                push_byte(b);
            end
            finish_rec();
            compare_trace("R2 R3 R4 R5 R12 random", 1'b0);
        end

        summary();
    end
endmodule